// File: doc/BRIEF.md
# Interrupt Delivery and End-of-Interrupt Engine

This block is the delivery core of an I/O interrupt router. It samples a set of interrupt input lines into a per-pin pending vector and scans the pending, unmasked pins, lowest number first. For each pin it picks, it forms a message-signalled address/data pair from that pin's routing entry and presents it on a valid/ready message port. The routing entries are supplied as a flat configuration input, so register access stays outside the block.

Level-sensitive pins carry an in-service flag that is set when a message leaves and blocks further messages from that pin. An end-of-interrupt (EOI) notice carries a vector. Every in-service pin whose entry holds that vector has its flag cleared, and a pin whose line is still high is delivered again. A per-pin counter tracks back-to-back re-deliveries. When the counter reaches a limit, the pin is parked until a holdoff timer expires, so a faulty handler cannot keep the router busy with one pin.

Routing entry layout, per pin, 30 bits: [7:0] vector, [10:8] delivery mode, [11] destination mode, [12] trigger (1 = level, 0 = edge), [13] mask, [29:14] destination index.

Top module: `irq_deliver_engine`

## Requirements
- R1: During reset and in the first cycle after it, `msg_valid` is 0, and no pin is pending or in service.
- R2: `msg_addr` equals 0xFEE00000 ORed with the 16-bit destination index shifted left by 12 and the destination mode bit shifted left by 2.
- R3: `msg_data` has the vector in bits [7:0], the delivery mode in bits [10:8] and the trigger bit in bit 15. All other bits are 0.
- R4: An edge pin sends one message for each rising edge of its line. A line that stays high sends nothing more.
- R5: A level pin whose line is high sends one message and then sets its in-service flag. No further message comes from that pin while the flag is set.
- R6: An EOI whose vector matches an in-service pin clears that pin's flag. The pin is delivered again if its line is still high. An EOI with a different vector has no effect.
- R7: A masked pin sends no message. If the pin is later unmasked with its request still pending, the message is sent.
- R8: When several pins are pending, messages go out in increasing pin order, one per accepted handshake.
- R9: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` hold their values.
- R10: Input 0 and input 2 both drive pin 2. Pin 0 is never raised. Every other input drives the pin with the same number.
- R11: When a matching EOI re-delivers a pin, that pin's counter increments. When the counter reaches STORM_LIMIT, the counter is reset and the re-delivery waits about HOLDOFF cycles.
- R12: A matching EOI that finds the pin's line low, or the pin masked, resets that pin's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | NPINS | Interrupt input lines |
| rte | input | NPINS*30 | Routing entries, pin 0 in the low bits |
| eoi_valid | input | 1 | EOI notice strobe, one cycle |
| eoi_vector | input | 8 | Vector carried by the EOI notice |
| msg_valid | output | 1 | Message is available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The tests below show which fault each input pattern would reveal.
- A single edge pulse compared with an edge line held high tells one message per edge apart from repeated firing.
- A level line held high across a matching EOI, across a non-matching EOI and across a dropped line tells correct in-service gating apart from vector-blind or line-blind clearing.
- Three edge pins raised together under back-pressure show the order in which pins are picked and whether the message holds still.
- Extreme field values (destination 0xFFFF, delivery mode 7) expose field overlap.
- A run of EOIs on a line that stays high shows whether the storm limit holds the pin back. Lowering the line partway through the run shows whether the counter is reset.

// File: rtl/irq_deliver_engine.sv
module irq_deliver_engine #(
  parameter int NPINS        = 24,
  parameter int STORM_LIMIT  = 10000,
  parameter int HOLDOFF      = 1024,
  parameter int LEGACY_REMAP = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPINS-1:0]    irq_in,
  input  logic [NPINS*30-1:0] rte,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [31:0]         msg_addr,
  output logic [31:0]         msg_data
);
  localparam int RTE_W = 30;
  localparam int PW    = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int CW    = $clog2(STORM_LIMIT + 1);
  localparam int TW    = $clog2(HOLDOFF + 1);
  localparam logic [31:0] ADDR_BASE = 32'hFEE0_0000;

  logic [NPINS-1:0] pin_line, line_q, irr_q, rirr_q, hold_q;
  logic [NPINS-1:0] level_m, mask_m, eligible, eoi_hit, refire, defer, cap_oh;
  logic [PW-1:0]    cap_idx;
  logic             load, tmr_run, expire;
  logic [TW-1:0]    tmr_q;
  logic [RTE_W-1:0] sel;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [7:0]    vec;
    logic [CW-1:0] cnt_q;

    if (LEGACY_REMAP != 0 && i == 0) begin : g_l0
      assign pin_line[i] = 1'b0;
    end else if (LEGACY_REMAP != 0 && i == 2) begin : g_l2
      assign pin_line[i] = irq_in[2] | irq_in[0];
    end else begin : g_id
      assign pin_line[i] = irq_in[i];
    end

    assign vec        = rte[i*RTE_W +: 8];
    assign level_m[i] = rte[i*RTE_W + 12];
    assign mask_m[i]  = rte[i*RTE_W + 13];
    assign eoi_hit[i] = eoi_valid && (vec == eoi_vector) && rirr_q[i];
    assign refire[i]  = eoi_hit[i] && !mask_m[i] && irr_q[i];
    assign defer[i]   = refire[i] &&
                        (({1'b0, cnt_q} + 1'b1) >= (CW+1)'(STORM_LIMIT));
    assign eligible[i] = irr_q[i] && !mask_m[i] && !hold_q[i] &&
                         !(level_m[i] && rirr_q[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q     <= '0;
        irr_q[i]  <= 1'b0;
        rirr_q[i] <= 1'b0;
        hold_q[i] <= 1'b0;
        line_q[i] <= 1'b0;
      end else begin
        line_q[i] <= pin_line[i];
        if (eoi_hit[i])
          cnt_q <= (refire[i] && !defer[i]) ? cnt_q + 1'b1 : '0;
        if (level_m[i])
          irr_q[i] <= pin_line[i];
        else
          irr_q[i] <= (irr_q[i] && !cap_oh[i]) || (pin_line[i] && !line_q[i]);
        if (!level_m[i])
          rirr_q[i] <= 1'b0;
        else
          rirr_q[i] <= (rirr_q[i] && !eoi_hit[i]) || cap_oh[i];
        hold_q[i] <= (hold_q[i] && !expire) || defer[i];
      end
    end
  end

  always_comb begin
    cap_idx = '0;
    for (int k = NPINS - 1; k >= 0; k--)
      if (eligible[k]) cap_idx = PW'(k);
  end

  assign load   = (|eligible) && (!msg_valid || msg_ready);
  assign cap_oh = load ? (NPINS'(1) << cap_idx) : '0;
  assign sel    = rte[int'(cap_idx)*RTE_W +: RTE_W];
  assign expire = tmr_run && (tmr_q <= TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_run <= 1'b0;
      tmr_q   <= '0;
    end else if ((|defer) && (!tmr_run || expire)) begin
      tmr_run <= 1'b1;
      tmr_q   <= TW'(HOLDOFF);
    end else if (expire) begin
      tmr_run <= 1'b0;
    end else if (tmr_run) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= ADDR_BASE | ({16'b0, sel[29:14]} << 12) | ({31'b0, sel[11]} << 2);
      msg_data  <= {16'b0, sel[12], 4'b0, sel[10:8], sel[7:0]};
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_deliver_engine_chk.sv
module irq_deliver_engine_chk #(
  parameter int NPINS = 24,
  parameter int PW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic             load,
  input logic [PW-1:0]    cap_idx,
  input logic [NPINS-1:0] hold_q
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !msg_valid);

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R2
  addr_form_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[31:28] == 4'hF && msg_addr[11:3] == '0 && msg_addr[1:0] == '0));

  // R3
  data_form_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_data[31:16] == '0 && msg_data[14:11] == '0));

  // R11
  held_pin_skip_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> !hold_q[cap_idx]);
endmodule

bind irq_deliver_engine irq_deliver_engine_chk #(.NPINS(NPINS), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .load(load),
  .cap_idx(cap_idx), .hold_q(hold_q)
);

// File: tb/tb_irq_deliver_engine.sv
`timescale 1ns/1ps
module tb_irq_deliver_engine;
  localparam int NP = 8;
  localparam int LIM = 3;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] irq_in = '0;
  logic [NP*30-1:0] rte = '0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic msg_valid, msg_ready;
  logic [31:0] msg_addr, msg_data;

  int checks = 0;
  int fails = 0;
  int n_msg = 0;
  string cur_req = "R1";
  logic [63:0] expq[$];
  logic rdy = 1'b1;

  always #2.5 clk = ~clk;
  assign msg_ready = rdy;

  irq_deliver_engine #(.NPINS(NP), .STORM_LIMIT(LIM), .HOLDOFF(HOLD)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .rte(rte), .eoi_valid(eoi_valid),
    .eoi_vector(eoi_vector), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  logic [7:0] m_vec[NP];
  logic [2:0] m_dlv[NP];
  logic m_dm[NP], m_lvl[NP];
  logic [15:0] m_dst[NP];

  task automatic set_rte(int p, logic [7:0] v, logic [2:0] dl, logic dm, logic lv, logic mk, logic [15:0] ds);
    m_vec[p] = v; m_dlv[p] = dl; m_dm[p] = dm; m_lvl[p] = lv; m_dst[p] = ds;
    rte[p*30 +: 30] = {ds, mk, lv, dm, dl, v};
  endtask

  task automatic expect_msg(int p);
    logic [31:0] a, d;
    a = 32'hFEE0_0000 | ({16'b0, m_dst[p]} << 12) | (m_dm[p] ? 32'h4 : 32'h0);
    d = {16'b0, m_lvl[p], 4'b0, m_dlv[p], m_vec[p]};
    expq.push_back({a, d});
  endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      n_msg++;
      if (expq.size() == 0) begin
        check(0, cur_req, {msg_addr, msg_data}, 64'h0);
      end else begin
        logic [63:0] e;
        e = expq.pop_front();
        check({msg_addr, msg_data} == e, cur_req, {msg_addr, msg_data}, e);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_msgs(int target, int maxc, string req);
    int k;
    k = 0;
    while (n_msg < target && k < maxc) begin
      @(negedge clk); k++;
    end
    check(n_msg >= target, req, 64'(n_msg), 64'(target));
  endtask

  task automatic quiet(int n, string req);
    int b;
    b = n_msg;
    cyc(n);
    check(n_msg == b, req, 64'(n_msg), 64'(b));
  endtask

  task automatic eoi(logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic pulse(int i);
    @(negedge clk); irq_in[i] = 1'b1;
    cyc(2); irq_in[i] = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    set_rte(0, 8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0001);
    set_rte(1, 8'h31, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0003);
    set_rte(2, 8'h22, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0002);
    set_rte(3, 8'h42, 3'd1, 1'b1, 1'b1, 1'b0, 16'h00A5);
    set_rte(4, 8'h50, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0004);
    set_rte(5, 8'h61, 3'd7, 1'b1, 1'b0, 1'b0, 16'hFFFF);
    set_rte(6, 8'h66, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0006);
    set_rte(7, 8'h77, 3'd2, 1'b0, 1'b0, 1'b0, 16'h1234);
    cyc(3);
    check(msg_valid == 1'b0, "R1 in reset", 64'(msg_valid), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check(msg_valid == 1'b0, "R1 after reset", 64'(msg_valid), 64'h0);
    quiet(5, "R1 idle");

    cur_req = "R4";
    expect_msg(1);
    @(negedge clk); irq_in[1] = 1'b1;
    wait_msgs(1, 10, "R4 edge delivered");
    quiet(12, "R4 held line no repeat");
    irq_in[1] = 1'b0;

    cur_req = "R2 R3";
    expect_msg(5);
    pulse(5);
    wait_msgs(2, 10, "R2 R3 extreme fields");

    cur_req = "R5";
    expect_msg(3);
    @(negedge clk); irq_in[3] = 1'b1;
    wait_msgs(3, 10, "R5 level delivered");
    quiet(15, "R5 in-service blocks");

    cur_req = "R6";
    eoi(8'h43);
    quiet(10, "R6 other vector ignored");
    expect_msg(3);
    eoi(8'h42);
    wait_msgs(4, 8, "R6 redeliver line high");
    irq_in[3] = 1'b0;
    cyc(2);
    eoi(8'h42);
    quiet(10, "R6 line low no redeliver");
    expect_msg(3);
    irq_in[3] = 1'b1;
    wait_msgs(5, 8, "R6 flag cleared by eoi");
    irq_in[3] = 1'b0;
    cyc(2);
    eoi(8'h42);

    cur_req = "R7";
    pulse(4);
    quiet(10, "R7 masked silent");
    m_lvl[4] = 1'b0;
    expect_msg(4);
    set_rte(4, 8'h50, 3'd0, 1'b0, 1'b0, 1'b0, 16'h0004);
    wait_msgs(6, 8, "R7 unmask delivers");

    cur_req = "R8 R9";
    rdy = 1'b0;
    expect_msg(1); expect_msg(5); expect_msg(7);
    @(negedge clk); irq_in[1] = 1'b1; irq_in[5] = 1'b1; irq_in[7] = 1'b1;
    cyc(2); irq_in = '0;
    cyc(3);
    begin
      logic [31:0] a0, d0;
      a0 = msg_addr; d0 = msg_data;
      check(msg_valid == 1'b1, "R9 valid under backpressure", 64'(msg_valid), 64'h1);
      cyc(4);
      check(msg_valid && msg_addr == a0 && msg_data == d0, "R9 stable",
            {msg_addr, msg_data}, {a0, d0});
    end
    rdy = 1'b1;
    wait_msgs(9, 12, "R8 three in order");

    cur_req = "R10";
    expect_msg(2);
    pulse(0);
    wait_msgs(10, 10, "R10 input 0 to pin 2");
    expect_msg(2);
    pulse(2);
    wait_msgs(11, 10, "R10 input 2 to pin 2");
    quiet(8, "R10 pin 0 silent");

    cur_req = "R11";
    expect_msg(6);
    @(negedge clk); irq_in[6] = 1'b1;
    wait_msgs(12, 10, "R11 first delivery");
    expect_msg(6); eoi(8'h66);
    wait_msgs(13, 8, "R11 refire 1");
    expect_msg(6); eoi(8'h66);
    wait_msgs(14, 8, "R11 refire 2");
    expect_msg(6); eoi(8'h66);
    quiet(30, "R11 storm holdoff");
    wait_msgs(15, 30, "R11 delivered after holdoff");

    cur_req = "R12";
    expect_msg(6); eoi(8'h66);
    wait_msgs(16, 8, "R12 refire 1");
    expect_msg(6); eoi(8'h66);
    wait_msgs(17, 8, "R12 refire 2");
    irq_in[6] = 1'b0;
    cyc(2);
    eoi(8'h66);
    quiet(8, "R12 no refire line low");
    expect_msg(6);
    irq_in[6] = 1'b1;
    wait_msgs(18, 8, "R12 raise again");
    expect_msg(6); eoi(8'h66);
    wait_msgs(19, 8, "R12 counter cleared 1");
    expect_msg(6); eoi(8'h66);
    wait_msgs(20, 8, "R12 counter cleared 2");
    irq_in[6] = 1'b0;
    cyc(2);
    eoi(8'h66);
    cyc(5);
    check(expq.size() == 0, "R8 scoreboard drained", 64'(expq.size()), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule